// File: doc/BRIEF.md
# Privilege-Masked Status Flags Unit

This block keeps a 16-bit processor status word and changes it on request. A request is a four-bit operation code with a one-cycle valid strobe and a 16-bit operand. There are three kinds of request. The first kind changes a single bit: the carry bit, the direction bit or the interrupt-enable bit. The second kind moves the low byte to or from an 8-bit accumulator value. The third kind loads the whole word from a value popped off the stack.

The whole-word load looks at three inputs: the protected-mode enable, the current privilege level and the I/O privilege level. From these it picks the set of bits the popped value may overwrite. The bits it may not touch keep their old values. A request to set or clear the interrupt bit that lacks enough privilege is refused: the status word is not changed and a one-cycle general-protection fault pulse is raised.

Every result appears on the clock edge that follows the strobe. The block is meant to sit beside an execution unit, which supplies the popped word and the privilege state and acts on the fault.

Top module: `flg_unit`

## Requirements
- R1: After a synchronous active-low reset, `flags` reads 0x0002, while `acc_byte` and `gp_fault` read 0.
- R2: Opcode 0 sets bit 0 (carry), opcode 1 clears it and opcode 2 inverts it. No other bit changes.
- R3: Opcode 3 sets bit 10 (direction) and opcode 4 clears it. No other bit changes.
- R4: Opcode 7 (byte load) makes the low byte `(op_data[7:0] & 0xD5) | 0x02`. The upper byte keeps its value.
- R5: Opcode 8 (byte store) puts `flags[7:0]` on `acc_byte` at the next edge and leaves `flags` unchanged.
- R6: Opcode 9 (word pop) with `prot_en`=0, or with `cpl`=0, makes `flags` equal to `(op_data & 0x7FD5) | 0x0002`.
- R7: A word pop with `prot_en`=1 and 0 < `cpl` <= `iopl` keeps bits 13:12. All other bits become `(op_data & 0x4FD5) | 0x0002`.
- R8: A word pop with `prot_en`=1 and `cpl` > `iopl` keeps bits 13:12 and bit 9. All other bits become `(op_data & 0x4DD5) | 0x0002`.
- R9: Opcode 5 sets bit 9 (interrupt enable) and opcode 6 clears it, when `prot_en`=0 or `cpl` <= `iopl`. No other bit changes and no fault is raised.
- R10: Opcode 5 or 6 with `prot_en`=1 and `cpl` > `iopl` is refused. `flags` is unchanged and `gp_fault` is high for exactly the one cycle after the edge.
- R11: A cycle with `op_valid`=0, or with an unassigned opcode (10 to 15), changes neither `flags` nor `acc_byte` and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe, one cycle per request |
| op_code | input | 4 | Operation selector |
| op_data | input | 16 | Popped word, or the accumulator byte in bits 7:0 |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| prot_en | input | 1 | Protected mode enable |
| flags | output | 16 | Status word |
| acc_byte | output | 8 | Low byte captured by a byte store |
| gp_fault | output | 1 | One-cycle pulse when a request is refused |

## Verification
The whole-word load is tried with all-ones and all-zeros operands under four cases: real mode, privilege 0, privilege at or below the I/O level, and privilege above it. An all-ones pop shows which bits are writable. A zero pop that follows shows which bits were kept from the old word, so an error in one mask cannot be hidden by another. Interrupt requests are issued with privilege both above and below the I/O level, in both modes, to separate a refusal from a write. Single-bit requests, byte load and store, idle cycles and unassigned opcodes are each checked for bits changed that should have been left alone.

// File: rtl/flg_pkg.sv
// Package: shared opcodes, pop-mode selector and bit masks for the flags unit.
// Assumes a 16-bit status word; bit positions are fixed by the behaviour.
package flg_pkg;
    localparam int FLAG_W = 16;
    localparam int BYTE_W = 8;
    localparam int LVL_W  = 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CY_SET  = 4'd0,
        OP_CY_CLR  = 4'd1,
        OP_CY_INV  = 4'd2,
        OP_DIR_SET = 4'd3,
        OP_DIR_CLR = 4'd4,
        OP_IE_SET  = 4'd5,
        OP_IE_CLR  = 4'd6,
        OP_LO_LOAD = 4'd7,
        OP_LO_STOR = 4'd8,
        OP_POP     = 4'd9
    } flg_op_e;

    typedef enum logic [1:0] {
        POP_FULL    = 2'd0,
        POP_KEEP_IO = 2'd1,
        POP_KEEP_IE = 2'd2
    } pop_sel_e;

    localparam int BIT_CY  = 0;
    localparam int BIT_ONE = 1;
    localparam int BIT_IE  = 9;
    localparam int BIT_DIR = 10;

    localparam logic [FLAG_W-1:0] RESET_VAL    = 16'h0002;
    localparam logic [FLAG_W-1:0] FIXED_ONE    = 16'h0002;
    localparam logic [BYTE_W-1:0] LO_WR_MASK   = 8'hD5;
    localparam logic [FLAG_W-1:0] POP_MASK_ALL = 16'h7FD5;
    localparam logic [FLAG_W-1:0] POP_MASK_IO  = 16'h4FD5;
    localparam logic [FLAG_W-1:0] POP_MASK_IE  = 16'h4DD5;
    localparam logic [FLAG_W-1:0] KEEP_IO      = 16'h3000;
    localparam logic [FLAG_W-1:0] KEEP_IO_IE   = 16'h3200;
endpackage

// File: rtl/flg_priv_check.sv
// Module: privilege classifier. Decides whether interrupt-bit requests
// are allowed and which write mask a word pop uses.
// Assumes a lower number means more privilege (0 is the most privileged).
module flg_priv_check
    import flg_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic [LW-1:0] cpl,
    input  logic [LW-1:0] iopl,
    input  logic          prot_en,
    output logic          io_ok,
    output pop_sel_e      pop_sel
);
    // Classify the current privilege against the I/O level and the mode.
    always_comb begin
        io_ok = !prot_en || (cpl <= iopl);
        if (!prot_en || (cpl == '0))
            pop_sel = POP_FULL;
        else if (cpl <= iopl)
            pop_sel = POP_KEEP_IO;
        else
            pop_sel = POP_KEEP_IE;
    end
endmodule

// File: rtl/flg_next.sv
// Module: next-state logic. Works out the new status word, the write enable,
// the byte-store enable and a refusal for one request.
// Assumes at most one request per cycle; a refused request writes nothing.
module flg_next
    import flg_pkg::*;
#(
    parameter int FW = FLAG_W,
    parameter int BW = BYTE_W
) (
    input  logic          valid,
    input  flg_op_e       op,
    input  logic [FW-1:0] data,
    input  logic [FW-1:0] cur,
    input  logic          io_ok,
    input  pop_sel_e      pop_sel,
    output logic [FW-1:0] nxt,
    output logic          wr_en,
    output logic          st_en,
    output logic          refuse
);
    localparam int HI_W = FW - BW;

    // Decode the request into its effect on the status word.
    always_comb begin
        nxt    = cur;
        wr_en  = 1'b0;
        st_en  = 1'b0;
        refuse = 1'b0;
        if (valid) begin
            case (op)
                OP_CY_SET:  begin nxt[BIT_CY] = 1'b1;         wr_en = 1'b1; end
                OP_CY_CLR:  begin nxt[BIT_CY] = 1'b0;         wr_en = 1'b1; end
                OP_CY_INV:  begin nxt[BIT_CY] = ~cur[BIT_CY]; wr_en = 1'b1; end
                OP_DIR_SET: begin nxt[BIT_DIR] = 1'b1;        wr_en = 1'b1; end
                OP_DIR_CLR: begin nxt[BIT_DIR] = 1'b0;        wr_en = 1'b1; end
                OP_IE_SET, OP_IE_CLR: begin
                    if (io_ok) begin
                        nxt[BIT_IE] = (op == OP_IE_SET);
                        wr_en       = 1'b1;
                    end else begin
                        refuse = 1'b1;
                    end
                end
                OP_LO_LOAD: begin
                    nxt   = {cur[FW-1:BW], (data[BW-1:0] & LO_WR_MASK)} | FIXED_ONE;
                    wr_en = 1'b1;
                end
                OP_LO_STOR: st_en = 1'b1;
                OP_POP: begin
                    wr_en = 1'b1;
                    case (pop_sel)
                        POP_FULL:    nxt = (data & POP_MASK_ALL) | FIXED_ONE;
                        POP_KEEP_IO: nxt = (cur & KEEP_IO) | (data & POP_MASK_IO) | FIXED_ONE;
                        default:     nxt = (cur & KEEP_IO_IE) | (data & POP_MASK_IE) | FIXED_ONE;
                    endcase
                end
                default: nxt = cur;
            endcase
        end
    end

    // The upper part of the word is never produced from the accumulator byte.
    if (HI_W <= 0) begin : g_bad_width
        initial $error("flg_next: word must be wider than a byte");
    end
endmodule

// File: rtl/flg_unit.sv
// Module: top of the status flags unit. Holds the status word, the stored
// accumulator byte and the fault pulse; all are updated on the edge after a request.
// Assumes a synchronous active-low reset and a single-cycle op_valid strobe.
module flg_unit
    import flg_pkg::*;
#(
    parameter int FW = FLAG_W,
    parameter int BW = BYTE_W,
    parameter int LW = LVL_W,
    parameter int OW = OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [OW-1:0] op_code,
    input  logic [FW-1:0] op_data,
    input  logic [LW-1:0] cpl,
    input  logic [LW-1:0] iopl,
    input  logic          prot_en,
    output logic [FW-1:0] flags,
    output logic [BW-1:0] acc_byte,
    output logic          gp_fault
);
    logic          io_ok;
    pop_sel_e      pop_sel;
    logic [FW-1:0] nxt;
    logic          wr_en, st_en, refuse;
    flg_op_e       op;

    assign op = flg_op_e'(op_code);

    flg_priv_check #(.LW(LW)) priv_i (
        .cpl(cpl), .iopl(iopl), .prot_en(prot_en),
        .io_ok(io_ok), .pop_sel(pop_sel)
    );

    flg_next #(.FW(FW), .BW(BW)) next_i (
        .valid(op_valid), .op(op), .data(op_data), .cur(flags),
        .io_ok(io_ok), .pop_sel(pop_sel),
        .nxt(nxt), .wr_en(wr_en), .st_en(st_en), .refuse(refuse)
    );

    // Register the status word, the stored byte and the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags    <= RESET_VAL;
            acc_byte <= '0;
            gp_fault <= 1'b0;
        end else begin
            gp_fault <= refuse;
            if (wr_en) flags <= nxt;
            if (st_en) acc_byte <= flags[BW-1:0];
        end
    end

    AST_CARRY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd2) |=> (flags[FW-1:1] == $past(flags[FW-1:1]))); // R2
    AST_DIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd3 || op_code == 4'd4)) |=>
        ({flags[FW-1:BIT_DIR+1], flags[BIT_DIR-1:0]} ==
         {$past(flags[FW-1:BIT_DIR+1]), $past(flags[BIT_DIR-1:0])})); // R3
    AST_LOAD_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd7) |=> (flags[FW-1:BW] == $past(flags[FW-1:BW]))); // R4
    AST_STORE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> (acc_byte == $past(flags[BW-1:0]) && $stable(flags))); // R5
    AST_POP_IOPL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9 && prot_en && cpl != '0) |=>
        (flags[13:12] == $past(flags[13:12]))); // R7
    AST_POP_IE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9 && prot_en && cpl > iopl) |=>
        (flags[BIT_IE] == $past(flags[BIT_IE]))); // R8
    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> $stable(flags)); // R10
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> $past(op_valid)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(flags) && $stable(acc_byte) && !gp_fault)); // R11
    AST_BIT1_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> flags[BIT_ONE]); // R4
endmodule

// File: tb/flg_unit_tb_top.sv
`timescale 1ns/1ps
module flg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [15:0] op_data;
    logic [1:0]  cpl, iopl;
    logic        prot_en;
    logic [15:0] flags;
    logic [7:0]  acc_byte;
    logic        gp_fault;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_f;

    always #4 clk = ~clk;

    flg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .cpl(cpl), .iopl(iopl), .prot_en(prot_en),
        .flags(flags), .acc_byte(acc_byte), .gp_fault(gp_fault)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; on return the result is visible.
    task automatic issue(input logic [3:0] code, input logic [15:0] d,
                         input logic pe, input logic [1:0] c, input logic [1:0] io);
        op_valid = 1'b1; op_code = code; op_data = d;
        prot_en = pe; cpl = c; iopl = io;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_data = '0;
        cpl = '0; iopl = '0; prot_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags", flags, 16'h0002);
        chk("R1 acc_byte", {8'h0, acc_byte}, 16'h0);
        chk("R1 gp_fault", {15'h0, gp_fault}, 16'h0);
        exp_f = 16'h0002;
    endtask

    task automatic t_carry();
        issue(4'd0, 16'hFFFF, 1'b1, 2'd3, 2'd0); exp_f[0] = 1'b1;
        chk("R2 set", flags, exp_f);
        issue(4'd2, 16'hFFFF, 1'b1, 2'd3, 2'd0); exp_f[0] = 1'b0;
        chk("R2 invert", flags, exp_f);
        issue(4'd2, 16'h0000, 1'b0, 2'd0, 2'd0); exp_f[0] = 1'b1;
        chk("R2 invert back", flags, exp_f);
        issue(4'd1, 16'hFFFF, 1'b0, 2'd0, 2'd0); exp_f[0] = 1'b0;
        chk("R2 clear", flags, exp_f);
    endtask

    task automatic t_dir();
        issue(4'd3, 16'h0000, 1'b1, 2'd3, 2'd0); exp_f[10] = 1'b1;
        chk("R3 set", flags, exp_f);
        issue(4'd4, 16'hFFFF, 1'b1, 2'd3, 2'd0); exp_f[10] = 1'b0;
        chk("R3 clear", flags, exp_f);
    endtask

    task automatic t_pop();
        issue(4'd9, 16'hFFFF, 1'b0, 2'd3, 2'd0); exp_f = 16'h7FD7;
        chk("R6 real mode all ones", flags, exp_f);
        issue(4'd9, 16'h0000, 1'b1, 2'd3, 2'd0); exp_f = 16'h3202;
        chk("R8 above io level zeros", flags, exp_f);
        issue(4'd9, 16'h0000, 1'b1, 2'd1, 2'd2); exp_f = 16'h3002;
        chk("R7 below io level zeros", flags, exp_f);
        issue(4'd9, 16'hFFFF, 1'b1, 2'd3, 2'd2); exp_f = 16'h7DD7;
        chk("R8 above io level ones", flags, exp_f);
        issue(4'd9, 16'h0000, 1'b1, 2'd0, 2'd0); exp_f = 16'h0002;
        chk("R6 privilege zero zeros", flags, exp_f);
        issue(4'd9, 16'hFFFF, 1'b1, 2'd1, 2'd1); exp_f = 16'h4FD7;
        chk("R7 equal io level ones", flags, exp_f);
    endtask

    task automatic t_byte();
        issue(4'd9, 16'hAB00, 1'b0, 2'd0, 2'd0); exp_f = 16'h2B02;
        chk("R6 setup", flags, exp_f);
        issue(4'd7, 16'h55FF, 1'b1, 2'd3, 2'd0); exp_f = 16'h2BD7;
        chk("R4 byte load", flags, exp_f);
        issue(4'd8, 16'h0000, 1'b1, 2'd3, 2'd0);
        chk("R5 stored byte", {8'h0, acc_byte}, 16'h00D7);
        chk("R5 flags kept", flags, exp_f);
        issue(4'd7, 16'hFF00, 1'b0, 2'd0, 2'd0); exp_f = 16'h2B02;
        chk("R4 bit1 forced", flags, exp_f);
    endtask

    task automatic t_intr();
        issue(4'd5, 16'h0000, 1'b1, 2'd3, 2'd0);
        chk("R10 fault raised", {15'h0, gp_fault}, 16'h1);
        chk("R10 flags kept", flags, exp_f);
        @(negedge clk);
        chk("R10 fault one cycle", {15'h0, gp_fault}, 16'h0);
        issue(4'd5, 16'h0000, 1'b1, 2'd2, 2'd3); exp_f[9] = 1'b1;
        chk("R9 set allowed", flags, exp_f);
        chk("R9 no fault", {15'h0, gp_fault}, 16'h0);
        issue(4'd6, 16'h0000, 1'b1, 2'd2, 2'd1);
        chk("R10 clear refused", flags, exp_f);
        chk("R10 clear fault", {15'h0, gp_fault}, 16'h1);
        issue(4'd6, 16'h0000, 1'b0, 2'd3, 2'd0); exp_f[9] = 1'b0;
        chk("R9 real mode clear", flags, exp_f);
        chk("R9 real mode no fault", {15'h0, gp_fault}, 16'h0);
    endtask

    task automatic t_ignore();
        op_valid = 1'b0; op_code = 4'd9; op_data = 16'hFFFF; prot_en = 1'b0;
        @(negedge clk);
        chk("R11 idle flags", flags, exp_f);
        issue(4'd12, 16'hFFFF, 1'b1, 2'd3, 2'd0);
        chk("R11 unassigned flags", flags, exp_f);
        chk("R11 unassigned fault", {15'h0, gp_fault}, 16'h0);
        issue(4'd8, 16'h0000, 1'b0, 2'd0, 2'd0);
        issue(4'd15, 16'hFFFF, 1'b0, 2'd0, 2'd0);
        chk("R11 unassigned acc", {8'h0, acc_byte}, {8'h0, exp_f[7:0]});
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_carry();
        t_dir();
        t_pop();
        t_byte();
        t_intr();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule